// File: doc/BRIEF.md
# Multiply-Result Register Hazard Monitor

The block watches the retirement stream of a pipeline that has a pair of multiply/divide result registers, called HI and LO here. It does not execute anything. Each accepted instruction carries a class (move into HI, move into LO, read from HI, read from LO, or an arithmetic operation that writes both) and its address. From these it keeps, for each of the two registers, the time and address of the last move-in, the last read and the last arithmetic operation. Time is counted in accepted instructions, not in clock cycles.

Two kinds of misuse are reported. A write to a register, either a move-in or an arithmetic operation, is too close when a read of that register retired fewer than three instructions before it. A read is corrupted when the other register of the pair was moved into after the last arithmetic operation, and no read of this register has happened since that operation. Each finding is reported one clock after the instruction is accepted. The report holds a reason code, the current address and the address of the earlier access that conflicts with it. A core with a second result-register pair uses a second instance, which keeps its own history.

Top module: `hilo_hazard_mon`

## Requirements
- R1: While `rst_n` is low and after it is released, all outputs are zero and every history record is empty until instructions are accepted.
- R2: The time count advances by one for each cycle with `retire_vld` high, whatever the class. Cycles with `retire_vld` low do not separate instructions.
- R3: Class code 1 (move into HI) or 2 (move into LO) is a spacing violation, reason 1, when the same register's last read is recorded and retired fewer than 3 instructions earlier. The prior address is that read's address. A distance of exactly 3 is legal.
- R4: Class code 5 (arithmetic operation) is a spacing violation, reason 2, when the last read of HI or of LO is fewer than 3 instructions old. When both are too close, the prior address is HI's read. Otherwise it is the read that is too close.
- R5: Class code 3 (read HI) or 4 (read LO) is corrupted, reason 3, when three things hold: the register's last arithmetic operation is recorded, its peer's last move-in is recorded and newer than that operation, and the register's own last read is either absent or older than that operation. The prior address is the peer's move-in address.
- R6: The peer of HI is LO and the peer of LO is HI. Each read is judged only against its peer's move-in.
- R7: Every history record is updated with the current time and address, whether or not a violation was found. An arithmetic operation updates the operation record of both registers.
- R8: A history record that has not been written since reset never takes part in a violation.
- R9: A violation produces `viol_pulse` for exactly one cycle, in the cycle after the instruction is accepted, with `viol_cur_pc` equal to that instruction's address. When `viol_pulse` is low, the reason and both addresses are zero.
- R10: Class codes 0, 6 and 7 change no history record and never raise a violation. They only advance time.
- R11: Two instances share no state. Traffic on one never raises a violation on the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| retire_vld | input | 1 | An instruction retires this cycle |
| retire_cls | input | 3 | Instruction class: 1 move-in HI, 2 move-in LO, 3 read HI, 4 read LO, 5 arithmetic, other values have no hazard meaning |
| retire_pc | input | AW | Address of the retiring instruction |
| viol_pulse | output | 1 | One-cycle violation flag |
| viol_reason | output | 2 | 0 none, 1 move-in spacing, 2 operation spacing, 3 read corrupted |
| viol_cur_pc | output | AW | Address of the offending instruction |
| viol_prior_pc | output | AW | Address of the earlier conflicting access |

## Verification
The history update and the judgement of an instruction happen in the same clock cycle. Its report sits in one output register, so every result is due exactly one clock after the edge that accepts the instruction. The bench drives inputs on the falling edge and updates its reference model at the same moment. It compares all four outputs against the model's expectation on the next falling edge, which is one rising edge later. Idle cycles placed between instructions show that the spacing rule counts instructions and not clocks.

// File: rtl/hilo_mon_pkg.sv
package hilo_mon_pkg;

  typedef enum logic [2:0] {
    CLS_NONE  = 3'd0,
    CLS_MT_HI = 3'd1,
    CLS_MT_LO = 3'd2,
    CLS_MF_HI = 3'd3,
    CLS_MF_LO = 3'd4,
    CLS_ARITH = 3'd5
  } retire_cls_e;

  typedef enum logic [1:0] {
    WHY_NONE    = 2'd0,
    WHY_MT_GAP  = 2'd1,
    WHY_OP_GAP  = 2'd2,
    WHY_CORRUPT = 2'd3
  } viol_why_e;

  // record slots kept per register
  localparam int REC_MT = 0;
  localparam int REC_MF = 1;
  localparam int REC_OP = 2;
  localparam int NUM_REC = 3;

  // register index
  localparam int IDX_HI = 0;
  localparam int IDX_LO = 1;
  localparam int NUM_REG = 2;

endpackage

// File: rtl/hilo_epoch_ctr.sv
module hilo_epoch_ctr #(
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [TW-1:0] now
);

  logic [TW-1:0] now_q;
  logic [TW-1:0] now_d;

  always_comb begin
    now_d = now_q;
    if (adv) now_d = now_q + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) now_q <= '0;
    else if (adv) now_q <= now_d;
  end

  assign now = now_q;

endmodule

// File: rtl/hilo_reg_track.sv
module hilo_reg_track
  import hilo_mon_pkg::*;
#(
  parameter int TW = 32,
  parameter int AW = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [TW-1:0]                 now,
  input  logic [AW-1:0]                 pc,
  input  logic [NUM_REC-1:0]            wr,
  output logic [NUM_REC-1:0]            rec_vld,
  output logic [NUM_REC-1:0][TW-1:0]    rec_age,
  output logic [NUM_REC-1:0][AW-1:0]    rec_pc
);

  for (genvar k = 0; k < NUM_REC; k++) begin : g_rec
    logic          vld_q, vld_d;
    logic [TW-1:0] time_q, time_d;
    logic [AW-1:0] pc_q, pc_d;

    always_comb begin
      vld_d  = vld_q;
      time_d = time_q;
      pc_d   = pc_q;
      if (wr[k]) begin
        vld_d  = 1'b1;
        time_d = now;
        pc_d   = pc;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q  <= 1'b0;
        time_q <= '0;
        pc_q   <= '0;
      end else if (wr[k]) begin
        vld_q  <= vld_d;
        time_q <= time_d;
        pc_q   <= pc_d;
      end
    end

    // age in accepted instructions; unsigned difference tolerates wrap
    assign rec_vld[k] = vld_q;
    assign rec_age[k] = now - time_q;
    assign rec_pc[k]  = pc_q;
  end

endmodule

// File: rtl/hilo_hazard_eval.sv
module hilo_hazard_eval
  import hilo_mon_pkg::*;
#(
  parameter int TW      = 32,
  parameter int AW      = 32,
  parameter int SPACING = 3
) (
  input  logic                                    vld,
  input  logic [2:0]                              cls,
  input  logic [NUM_REG-1:0][NUM_REC-1:0]         rec_vld,
  input  logic [NUM_REG-1:0][NUM_REC-1:0][TW-1:0] rec_age,
  input  logic [NUM_REG-1:0][NUM_REC-1:0][AW-1:0] rec_pc,
  output logic                                    hit,
  output logic [1:0]                              why,
  output logic [AW-1:0]                           prior_pc
);

  localparam logic [TW-1:0] GAP = TW'(SPACING);

  logic [NUM_REG-1:0] read_close;
  logic [NUM_REG-1:0] read_spoiled;

  for (genvar r = 0; r < NUM_REG; r++) begin : g_reg
    localparam int P = NUM_REG - 1 - r;
    assign read_close[r] = rec_vld[r][REC_MF] && (rec_age[r][REC_MF] < GAP);
    // peer move-in newer than our last op, and our last read older than it
    assign read_spoiled[r] = rec_vld[r][REC_OP] && rec_vld[P][REC_MT]
                          && (rec_age[P][REC_MT] < rec_age[r][REC_OP])
                          && (!rec_vld[r][REC_MF]
                              || (rec_age[r][REC_MF] > rec_age[r][REC_OP]));
  end

  always_comb begin
    hit      = 1'b0;
    why      = WHY_NONE;
    prior_pc = '0;
    if (vld) begin
      case (cls)
        CLS_MT_HI: if (read_close[IDX_HI]) begin
          hit = 1'b1; why = WHY_MT_GAP; prior_pc = rec_pc[IDX_HI][REC_MF];
        end
        CLS_MT_LO: if (read_close[IDX_LO]) begin
          hit = 1'b1; why = WHY_MT_GAP; prior_pc = rec_pc[IDX_LO][REC_MF];
        end
        CLS_ARITH: begin
          if (read_close[IDX_HI]) begin
            hit = 1'b1; why = WHY_OP_GAP; prior_pc = rec_pc[IDX_HI][REC_MF];
          end else if (read_close[IDX_LO]) begin
            hit = 1'b1; why = WHY_OP_GAP; prior_pc = rec_pc[IDX_LO][REC_MF];
          end
        end
        CLS_MF_HI: if (read_spoiled[IDX_HI]) begin
          hit = 1'b1; why = WHY_CORRUPT; prior_pc = rec_pc[IDX_LO][REC_MT];
        end
        CLS_MF_LO: if (read_spoiled[IDX_LO]) begin
          hit = 1'b1; why = WHY_CORRUPT; prior_pc = rec_pc[IDX_HI][REC_MT];
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/hilo_hazard_mon.sv
module hilo_hazard_mon
  import hilo_mon_pkg::*;
#(
  parameter int TW      = 32,
  parameter int AW      = 32,
  parameter int SPACING = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          retire_vld,
  input  logic [2:0]    retire_cls,
  input  logic [AW-1:0] retire_pc,
  output logic          viol_pulse,
  output logic [1:0]    viol_reason,
  output logic [AW-1:0] viol_cur_pc,
  output logic [AW-1:0] viol_prior_pc
);

  logic [TW-1:0] now;

  hilo_epoch_ctr #(.TW(TW)) u_epoch (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (retire_vld),
    .now   (now)
  );

  logic [NUM_REG-1:0][NUM_REC-1:0]         rec_vld;
  logic [NUM_REG-1:0][NUM_REC-1:0][TW-1:0] rec_age;
  logic [NUM_REG-1:0][NUM_REC-1:0][AW-1:0] rec_pc;
  logic [NUM_REG-1:0][NUM_REC-1:0]         rec_wr;

  for (genvar r = 0; r < NUM_REG; r++) begin : g_track
    localparam logic [2:0] MT_CODE = (r == IDX_HI) ? CLS_MT_HI : CLS_MT_LO;
    localparam logic [2:0] MF_CODE = (r == IDX_HI) ? CLS_MF_HI : CLS_MF_LO;

    always_comb begin
      rec_wr[r]         = '0;
      rec_wr[r][REC_MT] = retire_vld && (retire_cls == MT_CODE);
      rec_wr[r][REC_MF] = retire_vld && (retire_cls == MF_CODE);
      rec_wr[r][REC_OP] = retire_vld && (retire_cls == CLS_ARITH);
    end

    hilo_reg_track #(.TW(TW), .AW(AW)) u_track (
      .clk     (clk),
      .rst_n   (rst_n),
      .now     (now),
      .pc      (retire_pc),
      .wr      (rec_wr[r]),
      .rec_vld (rec_vld[r]),
      .rec_age (rec_age[r]),
      .rec_pc  (rec_pc[r])
    );
  end

  logic          hit;
  logic [1:0]    why;
  logic [AW-1:0] prior_pc;

  hilo_hazard_eval #(.TW(TW), .AW(AW), .SPACING(SPACING)) u_eval (
    .vld      (retire_vld),
    .cls      (retire_cls),
    .rec_vld  (rec_vld),
    .rec_age  (rec_age),
    .rec_pc   (rec_pc),
    .hit      (hit),
    .why      (why),
    .prior_pc (prior_pc)
  );

  logic          pulse_q, pulse_d;
  logic [1:0]    why_q, why_d;
  logic [AW-1:0] cur_q, cur_d, prior_q, prior_d;

  always_comb begin
    pulse_d = hit;
    why_d   = hit ? why : WHY_NONE;
    cur_d   = hit ? retire_pc : '0;
    prior_d = hit ? prior_pc : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      why_q   <= '0;
      cur_q   <= '0;
      prior_q <= '0;
    end else begin
      pulse_q <= pulse_d;
      why_q   <= why_d;
      cur_q   <= cur_d;
      prior_q <= prior_d;
    end
  end

  assign viol_pulse    = pulse_q;
  assign viol_reason   = why_q;
  assign viol_cur_pc   = cur_q;
  assign viol_prior_pc = prior_q;

endmodule

// File: rtl/hilo_hazard_mon_chk.sv
module hilo_hazard_mon_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          retire_vld,
  input logic [2:0]    retire_cls,
  input logic [AW-1:0] retire_pc,
  input logic          viol_pulse,
  input logic [1:0]    viol_reason,
  input logic [AW-1:0] viol_cur_pc,
  input logic [AW-1:0] viol_prior_pc
);

  p_pulse_after_retire_r9: assert property (@(posedge clk) disable iff (!rst_n)
    viol_pulse |-> $past(retire_vld));

  p_cur_pc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    viol_pulse |-> viol_cur_pc == $past(retire_pc));

  p_quiet_outputs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !viol_pulse |-> (viol_reason == 2'd0 && viol_cur_pc == '0 && viol_prior_pc == '0));

  p_reason_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    viol_pulse |-> viol_reason != 2'd0);

  p_mt_reason_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_pulse && viol_reason == 2'd1) |-> ($past(retire_cls) == 3'd1 || $past(retire_cls) == 3'd2));

  p_op_reason_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_pulse && viol_reason == 2'd2) |-> $past(retire_cls) == 3'd5);

  p_corrupt_reason_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_pulse && viol_reason == 2'd3) |-> ($past(retire_cls) == 3'd3 || $past(retire_cls) == 3'd4));

  p_ignored_class_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(retire_cls) == 3'd0 || $past(retire_cls) > 3'd5) |-> !viol_pulse);

endmodule

bind hilo_hazard_mon hilo_hazard_mon_chk #(.AW(AW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .retire_vld    (retire_vld),
  .retire_cls    (retire_cls),
  .retire_pc     (retire_pc),
  .viol_pulse    (viol_pulse),
  .viol_reason   (viol_reason),
  .viol_cur_pc   (viol_cur_pc),
  .viol_prior_pc (viol_prior_pc)
);

// File: tb/sim_hilo_hazard_mon.sv
`timescale 1ns/1ps
module sim_hilo_hazard_mon;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        vld;
  logic [2:0]  cls;
  logic [31:0] pc;
  logic        pulse;
  logic [1:0]  reason;
  logic [31:0] cur_pc, prior_pc;

  logic        vld1;
  logic [2:0]  cls1;
  logic [31:0] pc1;
  logic        pulse1;
  logic [1:0]  reason1;
  logic [31:0] cur1, prior1;

  always #5 clk = ~clk;

  hilo_hazard_mon u0 (
    .clk(clk), .rst_n(rst_n), .retire_vld(vld), .retire_cls(cls), .retire_pc(pc),
    .viol_pulse(pulse), .viol_reason(reason), .viol_cur_pc(cur_pc), .viol_prior_pc(prior_pc)
  );

  hilo_hazard_mon u1 (
    .clk(clk), .rst_n(rst_n), .retire_vld(vld1), .retire_cls(cls1), .retire_pc(pc1),
    .viol_pulse(pulse1), .viol_reason(reason1), .viol_cur_pc(cur1), .viol_prior_pc(prior1)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // behavioural reference: index 0 = HI, 1 = LO
  int          now_t;
  bit          mt_v[2], mf_v[2], op_v[2];
  int          mt_t[2], mf_t[2], op_t[2];
  logic [31:0] mt_p[2], mf_p[2], op_p[2];

  logic        e_pulse;
  logic [1:0]  e_reason;
  logic [31:0] e_cur, e_prior;
  string       e_tag;

  task automatic model_reset();
    now_t = 0;
    for (int i = 0; i < 2; i++) begin
      mt_v[i] = 0; mf_v[i] = 0; op_v[i] = 0;
      mt_t[i] = 0; mf_t[i] = 0; op_t[i] = 0;
      mt_p[i] = '0; mf_p[i] = '0; op_p[i] = '0;
    end
    e_pulse = 0; e_reason = 0; e_cur = '0; e_prior = '0; e_tag = "R1";
  endtask

  task automatic model_step(input bit v, input logic [2:0] c, input logic [31:0] a);
    int r;
    int p;
    e_pulse = 0; e_reason = 0; e_cur = '0; e_prior = '0;
    if (!v) return;
    case (c)
      3'd1, 3'd2: begin
        r = c - 1;
        if (mf_v[r] && mf_t[r] + 3 > now_t) begin
          e_pulse = 1; e_reason = 1; e_cur = a; e_prior = mf_p[r];
        end
        mt_v[r] = 1; mt_t[r] = now_t; mt_p[r] = a;
      end
      3'd3, 3'd4: begin
        r = c - 3; p = 1 - r;
        if (op_v[r] && mt_v[p] && mt_t[p] > op_t[r] && (!mf_v[r] || mf_t[r] < op_t[r])) begin
          e_pulse = 1; e_reason = 3; e_cur = a; e_prior = mt_p[p];
        end
        mf_v[r] = 1; mf_t[r] = now_t; mf_p[r] = a;
      end
      3'd5: begin
        if (mf_v[0] && mf_t[0] + 3 > now_t) begin
          e_pulse = 1; e_reason = 2; e_cur = a; e_prior = mf_p[0];
        end else if (mf_v[1] && mf_t[1] + 3 > now_t) begin
          e_pulse = 1; e_reason = 2; e_cur = a; e_prior = mf_p[1];
        end
        for (int i = 0; i < 2; i++) begin
          op_v[i] = 1; op_t[i] = now_t; op_p[i] = a;
        end
      end
      default: ;
    endcase
    now_t++;
  endtask

  task automatic compare(input string tag);
    checks++;
    if (pulse !== e_pulse || reason !== e_reason || cur_pc !== e_cur || prior_pc !== e_prior) begin
      errors++;
      $display("FAIL %s: got pulse=%0b reason=%0d cur=%h prior=%h, expected pulse=%0b reason=%0d cur=%h prior=%h",
               tag, pulse, reason, cur_pc, prior_pc, e_pulse, e_reason, e_cur, e_prior);
    end
    // R11: second instance only sees move-ins and must stay quiet
    checks++;
    if (pulse1 !== 1'b0) begin
      errors++;
      $display("FAIL R11: second instance pulse=%0b expected 0", pulse1);
    end
  endtask

  // one clock: compare previous result, then drive and model the new input
  task automatic step(input bit v, input logic [2:0] c, input logic [31:0] a, input string tag);
    @(negedge clk);
    compare(e_tag);
    vld = v; cls = c; pc = a;
    vld1 = v; cls1 = 3'd1; pc1 = a ^ 32'hFFFF_0000;
    model_step(v, c, a);
    e_tag = tag;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 3'd0, 32'h0, tag);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++; checks++;
        $display("FAIL watchdog: cycles=%0d expected < 100000", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 0; vld = 0; cls = 0; pc = 0; vld1 = 0; cls1 = 0; pc1 = 0;
    model_reset();
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1;
    idle(2, "R1");

    // R8: records empty after reset, nothing fires
    step(1, 3'd1, 32'h0000_1000, "R8");
    step(1, 3'd5, 32'h0000_1004, "R8");
    step(1, 3'd3, 32'h0000_1008, "R8");
    idle(1, "R9");

    // R3: move-in right after read of the same register
    step(1, 3'd4, 32'h0000_2000, "R3");
    step(1, 3'd2, 32'h0000_2004, "R3");
    idle(1, "R9");
    // R3 boundary: distance exactly 3 is legal
    step(1, 3'd3, 32'h0000_2100, "R3");
    step(1, 3'd0, 32'h0000_2104, "R10");
    step(1, 3'd6, 32'h0000_2108, "R10");
    step(1, 3'd1, 32'h0000_210C, "R3");
    // distance 2 violates
    step(1, 3'd4, 32'h0000_2200, "R3");
    step(1, 3'd7, 32'h0000_2204, "R10");
    step(1, 3'd2, 32'h0000_2208, "R3");
    // R6: read HI then move into LO does not clash
    step(1, 3'd3, 32'h0000_2300, "R6");
    step(1, 3'd2, 32'h0000_2304, "R6");

    // R2: idle cycles do not separate instructions
    idle(3, "R2");
    step(1, 3'd3, 32'h0000_3000, "R2");
    idle(6, "R2");
    step(1, 3'd1, 32'h0000_3004, "R2");
    idle(1, "R9");

    // R4: arithmetic after a read of LO, then after reads of both
    idle(0, "R4");
    step(1, 3'd0, 32'h0000_4000, "R4");
    step(1, 3'd0, 32'h0000_4004, "R4");
    step(1, 3'd0, 32'h0000_4008, "R4");
    step(1, 3'd4, 32'h0000_4010, "R4");
    step(1, 3'd5, 32'h0000_4014, "R4");
    step(1, 3'd4, 32'h0000_4018, "R4");
    step(1, 3'd3, 32'h0000_401C, "R4");
    step(1, 3'd5, 32'h0000_4020, "R4");
    idle(1, "R9");

    // R5/R6: op, move into LO, read HI -> corrupted
    idle(3, "R5");
    step(1, 3'd5, 32'h0000_5000, "R5");
    step(1, 3'd0, 32'h0000_5004, "R5");
    step(1, 3'd2, 32'h0000_5008, "R5");
    step(1, 3'd3, 32'h0000_500C, "R5");
    // R7: the read was recorded, so a second read is clean
    step(1, 3'd0, 32'h0000_5010, "R7");
    step(1, 3'd3, 32'h0000_5014, "R7");
    // peer direction: op, move into HI, read LO
    idle(2, "R6");
    step(1, 3'd5, 32'h0000_5100, "R6");
    step(1, 3'd1, 32'h0000_5104, "R6");
    step(1, 3'd4, 32'h0000_5108, "R6");
    // read after op with no newer peer move-in is clean
    step(1, 3'd0, 32'h0000_5200, "R5");
    step(1, 3'd0, 32'h0000_5204, "R5");
    step(1, 3'd5, 32'h0000_5208, "R5");
    step(1, 3'd3, 32'h0000_520C, "R5");
    // R7: violating move-in still updates its record; read LO then op then read LO
    step(1, 3'd4, 32'h0000_5300, "R7");
    step(1, 3'd2, 32'h0000_5304, "R7");
    step(1, 3'd0, 32'h0000_5308, "R7");
    step(1, 3'd0, 32'h0000_530C, "R7");
    step(1, 3'd0, 32'h0000_5310, "R7");
    step(1, 3'd5, 32'h0000_5314, "R7");
    step(1, 3'd1, 32'h0000_5318, "R7");
    step(1, 3'd4, 32'h0000_531C, "R7");
    idle(2, "R9");

    // R1: reset mid-stream clears history
    @(negedge clk);
    compare(e_tag);
    rst_n = 0; vld = 0; vld1 = 0;
    model_reset();
    repeat (2) @(negedge clk);
    compare("R1");
    rst_n = 1;
    step(1, 3'd2, 32'h0000_6000, "R1");
    idle(2, "R9");

    @(negedge clk);
    compare(e_tag);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule